// File: doc/BRIEF.md
# Clock Fanout Output Gating and PLL Mode Controller

This block sits between the configuration state of a multi-output clock fanout and its output stages. It decides, for each output, whether the output runs or is held low, and it produces the PLL power, bypass and bandwidth selection, the input/output frequency code and the output amplitude code. Each output's run decision comes from the power control input, a hardware enable pin (active low), a software enable bit and the PLL lock flag. The decision is registered in the control clock domain and then resynchronised into that output's own clock domain. The final gate changes on the falling edge of the output clock, so a gated clock never carries a shortened pulse.

The PLL operating mode comes from a three-level bandwidth strap, which is captured once at the first power-up. Software can override it through a mode register. A frequency register selects the frequency code when its enable bit is set. The reserved frequency code is refused, and the previous setting is kept. Both registers are written over a simple byte-wide write strobe and can be read back at all times.

Top module: `clkfan_gate_ctrl`

## Requirements
- R1: While `pwr_on` is 0, every `gate_en` bit ends at 0 and `pll_pwr_on` is 0, whatever the other inputs are.
- R2: With `pwr_on` at 1 and a usable clock source, output i runs (`gate_en[i]`=1) exactly when `sw_oe[i]`=1 and `oe_pin_n[i]`=0. Otherwise it is held at 0.
- R3: Outside bypass mode, no output runs while `pll_locked` is 0. In bypass mode, `pll_locked` has no effect on the outputs.
- R4: After an enable input changes, `gate_en[i]` follows within 1 to 3 rising edges of `out_clk[i]`, counted from the control-clock edge that samples the change. It changes only while `out_clk[i]` is low.
- R5: The strap is sampled on the first clock edge with `pwr_on`=1 after reset. Later power-down and power-up cycles do not resample it.
- R6: The strap decodes as 00 (low level) to mode 00, 10 (high level) to mode 11, and 01 or 11 (mid level) to mode 01. The latched code reads back at `mode_rd[7:6]`.
- R7: The mode register (`cfg_sel`=0) holds an override enable at bit 5 and a mode at bits [4:3]. The effective mode is the register mode when bit 5 is 1, and the strap code otherwise. Mode 01 sets `pll_bypass`, mode 11 sets `pll_bw_high`, modes 00 and 10 are low bandwidth, and `pll_pwr_on` = `pwr_on` and not bypass.
- R8: Mode register bits [1:0] drive `amp_code` and reset to 10. Readback is {strap, bit5, bits[4:3], 0, bits[1:0]}.
- R9: The frequency register (`cfg_sel`=1) holds an enable at bit 5 and a code at bits [4:3]. `freq_code` is that code when the enable is 1, and 00 otherwise. Readback is {00, enable, code, 000}.
- R10: A frequency write with bits [4:3] = 11 leaves the stored code unchanged, though the enable bit is still written. `freq_code` is never 11.
- R11: After reset, `gate_en` is 0, `mode_rd` is 0x02, `freq_rd` is 0x00, `freq_code` is 00 and `amp_code` is 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_on | input | 1 | Power control, 0 = power down |
| oe_pin_n | input | N_OUT | Hardware output enables, active low |
| sw_oe | input | N_OUT | Software output enables |
| pll_locked | input | 1 | PLL lock flag |
| bw_strap | input | 2 | Three-level strap: 00 low, 01/11 mid, 10 high |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = mode register, 1 = frequency register |
| cfg_wdata | input | 8 | Register write data |
| out_clk | input | N_OUT | Per-output clocks |
| gclk | output | N_OUT | Gated output clocks |
| gate_en | output | N_OUT | Per-output gate state |
| pll_pwr_on | output | 1 | PLL power enable |
| pll_bypass | output | 1 | PLL bypass selected |
| pll_bw_high | output | 1 | High PLL bandwidth selected |
| freq_code | output | 2 | Frequency select code |
| amp_code | output | 2 | Output amplitude code |
| mode_rd | output | 8 | Mode register readback |
| freq_rd | output | 8 | Frequency register readback |

## Verification
The bench builds the block with six outputs and a two-stage synchroniser. Output 0 is clocked in phase with the control clock, and outputs 1 to 5 run at slower, unrelated periods. This setup exercises both the aligned worst-case latency count and true clock-domain crossings. Random mixes of power, pin, software-enable, lock, strap and register writes are compared against a reference model in the bench. Directed steps cover strap latching across power cycles, bypass against lock, and the refused reserved frequency code.

// File: rtl/clkfan_pkg.sv
// Shared types and helpers for the clock fanout controller.
// Assumes the strap is presented as a two-bit level code.
package clkfan_pkg;

    typedef enum logic [1:0] {
        MODE_LOW_BW  = 2'b00,
        MODE_BYPASS  = 2'b01,
        MODE_LOW_ALT = 2'b10,
        MODE_HIGH_BW = 2'b11
    } pll_mode_e;

    localparam logic [1:0] FREQ_RESERVED = 2'b11;
    localparam logic [1:0] AMP_DEFAULT   = 2'b10;

    // Map a three-level strap reading onto a PLL mode code.
    function automatic logic [1:0] strap_to_mode(input logic [1:0] level);
        case (level)
            2'b00:   strap_to_mode = MODE_LOW_BW;
            2'b10:   strap_to_mode = MODE_HIGH_BW;
            default: strap_to_mode = MODE_BYPASS;
        endcase
    endfunction

endpackage

// File: rtl/clkfan_strap_latch.sv
// Captures the bandwidth strap on the first cycle with power on after reset.
// Assumes the strap is static around the first power-up; never resamples.
module clkfan_strap_latch
    import clkfan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_on,
    input  logic [1:0] bw_strap,
    output logic [1:0] strap_mode,
    output logic       strap_valid
);

    // One-shot capture of the decoded strap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_mode  <= MODE_LOW_BW;
            strap_valid <= 1'b0;
        end else if (pwr_on && !strap_valid) begin
            strap_mode  <= strap_to_mode(bw_strap);
            strap_valid <= 1'b1;
        end
    end

    a_r5_strap_held: assert property (@(posedge clk) disable iff (!rst_n)
        strap_valid |=> (strap_valid && $stable(strap_mode)));

endmodule

// File: rtl/clkfan_cfg_regs.sv
// Mode and frequency registers with strap override and readback.
// Assumes single-cycle write strobes in the control clock domain.
module clkfan_cfg_regs
    import clkfan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic       cfg_sel,
    input  logic [7:0] cfg_wdata,
    input  logic [1:0] strap_mode,
    output logic [1:0] eff_mode,
    output logic [1:0] freq_code,
    output logic [1:0] amp_code,
    output logic [7:0] mode_rd,
    output logic [7:0] freq_rd
);

    logic       mode_ovr_q;
    logic [1:0] mode_sw_q;
    logic [1:0] amp_q;
    logic       freq_en_q;
    logic [1:0] freq_sel_q;
    logic       wr_mode;
    logic       wr_freq;

    assign wr_mode = cfg_wr && !cfg_sel;
    assign wr_freq = cfg_wr &&  cfg_sel;

    // Mode register: override enable, software mode, amplitude.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_ovr_q <= 1'b0;
            mode_sw_q  <= MODE_LOW_BW;
            amp_q      <= AMP_DEFAULT;
        end else if (wr_mode) begin
            mode_ovr_q <= cfg_wdata[5];
            mode_sw_q  <= cfg_wdata[4:3];
            amp_q      <= cfg_wdata[1:0];
        end
    end

    // Frequency register: enable always written, reserved code refused.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_en_q  <= 1'b0;
            freq_sel_q <= 2'b00;
        end else if (wr_freq) begin
            freq_en_q <= cfg_wdata[5];
            if (cfg_wdata[4:3] != FREQ_RESERVED) begin
                freq_sel_q <= cfg_wdata[4:3];
            end
        end
    end

    // Effective selections and readback assembly.
    always_comb begin
        eff_mode  = mode_ovr_q ? mode_sw_q : strap_mode;
        freq_code = freq_en_q ? freq_sel_q : 2'b00;
        amp_code  = amp_q;
        mode_rd   = {strap_mode, mode_ovr_q, mode_sw_q, 1'b0, amp_q};
        freq_rd   = {2'b00, freq_en_q, freq_sel_q, 3'b000};
    end

    a_r10_reserved_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_freq && cfg_wdata[4:3] == FREQ_RESERVED) |=> $stable(freq_sel_q));

    a_r10_no_reserved_out: assert property (@(posedge clk) disable iff (!rst_n)
        freq_code != FREQ_RESERVED);

endmodule

// File: rtl/clkfan_out_gate.sv
// Per-output gate: synchronises the run request into the output clock
// domain and updates the gate on the falling edge, so the gated clock has
// only full-width pulses. Assumes rst_n is held for several output clocks.
module clkfan_out_gate #(
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk_out,
    input  logic rst_n,
    input  logic run_req,
    output logic gate_en,
    output logic gclk
);

    localparam int LAST = SYNC_DEPTH - 1;

    logic [LAST:0] sync_q;
    logic          gate_q;

    // Synchroniser chain on the output clock rising edge.
    always_ff @(posedge clk_out) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q[0] <= run_req;
            for (int k = 1; k < SYNC_DEPTH; k++) begin
                sync_q[k] <= sync_q[k-1];
            end
        end
    end

    // Gate update while the output clock is low.
    always_ff @(negedge clk_out) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= sync_q[LAST];
        end
    end

    assign gate_en = gate_q;
    assign gclk    = clk_out & gate_q;

    a_r4_gate_from_sync: assert property (@(posedge clk_out) disable iff (!rst_n)
        ($rose(gate_q) || $fell(gate_q)) |-> (gate_q == sync_q[LAST]));

endmodule

// File: rtl/clkfan_gate_ctrl.sv
// Top level: qualifies each output's run request from power, pins,
// software enables and the clock source state, and drives the PLL
// configuration. Assumes out_clk bits are free-running during reset.
module clkfan_gate_ctrl
    import clkfan_pkg::*;
#(
    parameter int N_OUT      = 6,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_on,
    input  logic [N_OUT-1:0] oe_pin_n,
    input  logic [N_OUT-1:0] sw_oe,
    input  logic             pll_locked,
    input  logic [1:0]       bw_strap,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [7:0]       cfg_wdata,
    input  logic [N_OUT-1:0] out_clk,
    output logic [N_OUT-1:0] gclk,
    output logic [N_OUT-1:0] gate_en,
    output logic             pll_pwr_on,
    output logic             pll_bypass,
    output logic             pll_bw_high,
    output logic [1:0]       freq_code,
    output logic [1:0]       amp_code,
    output logic [7:0]       mode_rd,
    output logic [7:0]       freq_rd
);

    logic [1:0]       strap_mode;
    logic             strap_valid;
    logic [1:0]       eff_mode;
    logic             src_ok;
    logic [N_OUT-1:0] run_q;

    clkfan_strap_latch u_strap (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_on      (pwr_on),
        .bw_strap    (bw_strap),
        .strap_mode  (strap_mode),
        .strap_valid (strap_valid)
    );

    clkfan_cfg_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .strap_mode (strap_mode),
        .eff_mode   (eff_mode),
        .freq_code  (freq_code),
        .amp_code   (amp_code),
        .mode_rd    (mode_rd),
        .freq_rd    (freq_rd)
    );

    // PLL selection from the effective mode and power state.
    always_comb begin
        pll_bypass  = (eff_mode == MODE_BYPASS);
        pll_bw_high = (eff_mode == MODE_HIGH_BW);
        pll_pwr_on  = pwr_on && !pll_bypass;
        src_ok      = pll_bypass || pll_locked;
    end

    // Registered per-output run request in the control domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= sw_oe & ~oe_pin_n & {N_OUT{pwr_on && src_ok}};
        end
    end

    for (genvar g = 0; g < N_OUT; g++) begin : g_out
        clkfan_out_gate #(.SYNC_DEPTH(SYNC_DEPTH)) u_gate (
            .clk_out (out_clk[g]),
            .rst_n   (rst_n),
            .run_req (run_q[g]),
            .gate_en (gate_en[g]),
            .gclk    (gclk[g])
        );
    end

    a_r1_pwrdn_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |=> (run_q == '0));

    a_r3_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!pll_locked && !pll_bypass) |=> (run_q == '0));

endmodule

// File: tb/tb_clkfan_gate_ctrl.sv
`timescale 1ns/1ps
module tb_clkfan_gate_ctrl;

    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         pwr_on;
    logic [N-1:0] oe_pin_n;
    logic [N-1:0] sw_oe;
    logic         pll_locked;
    logic [1:0]   bw_strap;
    logic         cfg_wr;
    logic         cfg_sel;
    logic [7:0]   cfg_wdata;
    logic [N-1:0] out_clk;
    logic [N-1:0] gclk;
    logic [N-1:0] gate_en;
    logic         pll_pwr_on;
    logic         pll_bypass;
    logic         pll_bw_high;
    logic [1:0]   freq_code;
    logic [1:0]   amp_code;
    logic [7:0]   mode_rd;
    logic [7:0]   freq_rd;

    int checks = 0;
    int fails  = 0;

    // reference model state
    logic       m_seen;
    logic [1:0] m_strap;
    logic       m_ovr;
    logic [1:0] m_mode;
    logic [1:0] m_amp;
    logic       m_fen;
    logic [1:0] m_fsel;

    always #4 clk = ~clk;

    for (genvar g = 0; g < N; g++) begin : g_oc
        logic c = 1'b0;
        always #(4 + g) c = ~c;
        assign out_clk[g] = c;
    end

    clkfan_gate_ctrl #(.N_OUT(N), .SYNC_DEPTH(2)) dut (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .oe_pin_n(oe_pin_n),
        .sw_oe(sw_oe), .pll_locked(pll_locked), .bw_strap(bw_strap),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .out_clk(out_clk), .gclk(gclk), .gate_en(gate_en),
        .pll_pwr_on(pll_pwr_on), .pll_bypass(pll_bypass),
        .pll_bw_high(pll_bw_high), .freq_code(freq_code),
        .amp_code(amp_code), .mode_rd(mode_rd), .freq_rd(freq_rd)
    );

    function automatic logic [1:0] dec_strap(input logic [1:0] lvl);
        if (lvl == 2'b00)      return 2'b00;
        else if (lvl == 2'b10) return 2'b11;
        else                   return 2'b01;
    endfunction

    function automatic logic [1:0] exp_mode();
        return m_ovr ? m_mode : m_strap;
    endfunction

    function automatic logic [N-1:0] exp_gate();
        logic ok;
        ok = pwr_on && ((exp_mode() == 2'b01) || pll_locked);
        return ok ? (sw_oe & ~oe_pin_n) : '0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic note_power();
        if (pwr_on && !m_seen) begin
            m_seen  = 1'b1;
            m_strap = dec_strap(bw_strap);
        end
    endtask

    task automatic settle();
        repeat (12) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_reg(input logic sel, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (!sel) begin
            m_ovr = d[5]; m_mode = d[4:3]; m_amp = d[1:0];
        end else begin
            m_fen = d[5];
            if (d[4:3] != 2'b11) m_fsel = d[4:3];
        end
    endtask

    task automatic check_all(input string ctx);
        logic [1:0] md;
        md = exp_mode();
        check({ctx, " R2 gate_en"}, 32'(gate_en), 32'(exp_gate()));
        check({ctx, " R7 bypass"}, 32'(pll_bypass), 32'(md == 2'b01));
        check({ctx, " R7 bw_high"}, 32'(pll_bw_high), 32'(md == 2'b11));
        check({ctx, " R7 pll_pwr_on"}, 32'(pll_pwr_on), 32'(pwr_on && md != 2'b01));
        check({ctx, " R9 freq_code"}, 32'(freq_code), 32'(m_fen ? m_fsel : 2'b00));
        check({ctx, " R8 mode_rd"}, 32'(mode_rd), 32'({m_strap, m_ovr, m_mode, 1'b0, m_amp}));
        check({ctx, " R9 freq_rd"}, 32'(freq_rd), 32'({2'b00, m_fen, m_fsel, 3'b000}));
    endtask

    task automatic measure_latency(input logic exp_val);
        int lat;
        lat = 99;
        for (int k = 1; k <= 6; k++) begin
            @(posedge out_clk[0]);
            @(negedge out_clk[0]);
            #1;
            if (gate_en[0] == exp_val) begin
                lat = k;
                break;
            end
        end
        checks++;
        if (lat < 1 || lat > 3) begin
            fails++;
            $display("FAIL R4 latency: actual %0d expected 1..3", lat);
        end
    endtask

    initial begin
        #1_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        m_seen = 0; m_strap = 2'b00; m_ovr = 0; m_mode = 2'b00; m_amp = 2'b10;
        m_fen = 0; m_fsel = 2'b00;
        rst_n = 0; pwr_on = 0; oe_pin_n = '0; sw_oe = '1; pll_locked = 0;
        bw_strap = 2'b10; cfg_wr = 0; cfg_sel = 0; cfg_wdata = '0;
        repeat (6) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        settle();
        // R11 reset state
        check("R11 gate_en", 32'(gate_en), 32'h0);
        check("R11 mode_rd", 32'(mode_rd), 32'h02);
        check("R11 freq_rd", 32'(freq_rd), 32'h00);
        check("R11 freq_code", 32'(freq_code), 32'h0);
        check("R11 amp_code", 32'(amp_code), 32'h2);
        check("R1 pll_pwr_on while down", 32'(pll_pwr_on), 32'h0);

        // R3: power on, not locked, high-level strap
        pwr_on = 1; note_power();
        settle();
        check("R3 unlocked gates", 32'(gate_en), 32'h0);
        check("R6 strap readback", 32'(mode_rd[7:6]), 32'h3);
        check_all("R3 unlocked");

        pll_locked = 1;
        settle();
        check("R2 all running", 32'(gate_en), 32'h3f);
        check_all("R2 locked");

        // R4 latency on output 0, stop then start
        @(negedge clk);
        oe_pin_n[0] = 1'b1;
        measure_latency(1'b0);
        @(negedge clk);
        oe_pin_n[0] = 1'b0;
        measure_latency(1'b1);

        // R1 and R5: power cycle with different strap
        settle();
        bw_strap = 2'b01;
        pwr_on = 0;
        settle();
        check("R1 gates down", 32'(gate_en), 32'h0);
        check("R1 pll off", 32'(pll_pwr_on), 32'h0);
        pwr_on = 1;
        settle();
        check("R5 no resample", 32'(mode_rd[7:6]), 32'h3);
        check("R5 high bw kept", 32'(pll_bw_high), 32'h1);

        // R7 and R8: override to bypass, amplitude 01
        write_reg(1'b0, 8'b0010_1001);
        pll_locked = 0;
        settle();
        check("R7 bypass on", 32'(pll_bypass), 32'h1);
        check("R3 bypass ignores lock", 32'(gate_en), 32'h3f);
        check("R8 amp_code", 32'(amp_code), 32'h1);
        check_all("R7 override");

        // R9 and R10: frequency selection
        write_reg(1'b1, 8'h28);
        settle();
        check("R9 freq 01", 32'(freq_code), 32'h1);
        write_reg(1'b1, 8'h38);
        settle();
        check("R10 reserved refused", 32'(freq_code), 32'h1);
        write_reg(1'b1, 8'h30);
        settle();
        check("R9 freq 10", 32'(freq_code), 32'h2);
        write_reg(1'b1, 8'h08);
        settle();
        check("R9 disabled code", 32'(freq_code), 32'h0);
        check("R9 readback", 32'(freq_rd), 32'h08);
        write_reg(1'b1, 8'h18);
        settle();
        check("R10 enable still written", 32'(freq_rd), 32'h08);

        // random mix
        for (int it = 0; it < 150; it++) begin
            @(negedge clk);
            if ($urandom_range(0, 3) == 0) begin
                write_reg($urandom_range(0, 1) == 1, 8'($urandom));
            end
            pwr_on     = ($urandom_range(0, 3) != 0);
            oe_pin_n   = N'($urandom);
            sw_oe      = N'($urandom);
            pll_locked = ($urandom_range(0, 2) != 0);
            bw_strap   = 2'($urandom);
            note_power();
            settle();
            check_all("random");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule